// File: doc/BRIEF.md
# Crossbar Message Port Controller

This block is the per-port sequencer that moves framed messages from an inbound word stream into a crossbar. A message is a header word, any number of data words, and a tail word. A side control bit marks the header and the tail. The controller waits for a pending word and takes the header. From the header it works out where the message goes. It then raises a request to the crossbar arbiter and forwards every word to the outbound link. It only does this while the arbiter grants the port and the outbound link has room.

Two kinds of delivery are supported. A point-to-point message goes to the one port named in the header. A broadcast message is copied to every other port. Each word is written once per peer before the next word is taken from the inbound stream. The crossbar steers the outbound link to the port shown on `dest` at the moment of each write. The arbiter may withdraw the grant at any point. The controller then freezes on the word it holds and carries on when the grant returns.

Top module: `msg_port_fsm`

## Requirements
- R1: After reset, `req`, `out_wr` and `in_pop` are all low.
- R2: With no message in progress, a pending word whose control bit is 1 is popped as a header. A pending word whose control bit is 0 is popped and dropped, and no write results from it.
- R3: The destination port is taken from header bits [2:1], which are the low two bits of the destination field in bits [4:1]. The command field is header bits [12:9]. Value 2 selects broadcast, and any other value selects point-to-point delivery. Bit 0 is the header marker. The word count sits in bits [26:17] and is carried through untouched.
- R4: `in_pop` is only raised while `in_avail` is high. Once the header has been taken, no later word is popped and no state is left unless `grant` is high.
- R5: `out_wr` is only raised while `grant` is high, `out_full` is low and `req` is high. Header and tail are written with `out_ctrl` = 1. Data words are written with `out_ctrl` = 0. Every word leaves with its 32 bits unchanged.
- R6: Any pattern of `grant` and `out_full` stalls loses, repeats and reorders no word. While the port requests but lacks the grant, the held outbound word stays stable.
- R7: Delivery ends with the tail word. In the cycle after the tail's final write, `req` is low and the port is back waiting for a new message.
- R8: In broadcast, each word is written to every port except the port's own index (`PORT_IDX`). The order runs upward from `PORT_IDX`+1, wraps modulo `NUM_PORTS` and skips the own index. All copies of one word are written before the next word is popped.
- R9: While `req` is high and `grant` is low, `dest` does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Word at the head of the inbound stream |
| in_ctrl | input | 1 | Control bit of the inbound word (1 = header or tail) |
| in_avail | input | 1 | Inbound stream holds at least one word |
| in_pop | output | 1 | Consume the inbound head word at this edge |
| out_data | output | DATA_W | Word offered to the outbound link |
| out_ctrl | output | 1 | Control bit written with the word |
| out_wr | output | 1 | Write strobe to the outbound link |
| out_full | input | 1 | Outbound link cannot accept a word |
| req | output | 1 | Request to the crossbar arbiter |
| dest | output | PW | Crossbar port targeted by the current word |
| grant | input | 1 | Arbiter permission for this port |

## Verification
The assertions assume the inbound stream behaves like a FIFO head. `in_data` and `in_ctrl` only change after a pop or when the stream goes from empty to non-empty, and messages are well framed. The bench builds the inbound side as a queue that pops exactly when `in_pop` was high at the edge, so this assumption holds. `grant` and `out_full` are free inputs. The bench drives them in fixed patterns and in random patterns between clock edges, and every ordering of stalls is legal for the design.

// File: rtl/msg_port_pkg.sv
package msg_port_pkg;

  typedef enum logic [2:0] {
    ST_CHECK   = 3'd0,
    ST_HEADER  = 3'd1,
    ST_EXTRACT = 3'd2,
    ST_SEND    = 3'd3,
    ST_FETCH   = 3'd4
  } port_state_e;

  localparam int HDR_DST_LSB = 1;
  localparam int HDR_CMD_LSB = 9;
  localparam int HDR_CMD_W   = 4;
  localparam logic [HDR_CMD_W-1:0] CMD_BCAST = 4'd2;

  // Next broadcast peer after cur, skipping own index, wrapping at nports.
  function automatic int next_peer(int cur, int self_idx, int nports);
    int n;
    n = (cur + 1) % nports;
    if (n == self_idx) n = (n + 1) % nports;
    return n;
  endfunction

  function automatic logic [HDR_CMD_W-1:0] hdr_cmd(logic [31:0] w);
    return w[HDR_CMD_LSB +: HDR_CMD_W];
  endfunction

endpackage

// File: rtl/msg_word_hold.sv
module msg_word_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_is_hdr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ctrl,
  output logic [DATA_W-1:0] word,
  output logic              word_ctrl,
  output logic              word_is_tail
);
  logic is_hdr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word      <= '0;
      word_ctrl <= 1'b0;
      is_hdr_q  <= 1'b0;
    end else if (load) begin
      word      <= load_data;
      word_ctrl <= load_ctrl;
      is_hdr_q  <= load_is_hdr;
    end
  end

  assign word_is_tail = word_ctrl && !is_hdr_q;
endmodule

// File: rtl/msg_bcast_seq.sv
module msg_bcast_seq
  import msg_port_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_IDX  = 0,
  parameter int PW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_dst,
  input  logic          load_bcast,
  input  logic          advance,
  output logic [PW-1:0] dest,
  output logic          bcast,
  output logic          last_copy
);
  localparam logic [NUM_PORTS-1:0] SELF_BIT = NUM_PORTS'(1) << PORT_IDX;
  localparam logic [NUM_PORTS-1:0] ALL_BITS = {NUM_PORTS{1'b1}};
  localparam logic [PW-1:0]        FIRST    = PW'(next_peer(PORT_IDX, PORT_IDX, NUM_PORTS));

  logic [NUM_PORTS-1:0] sent_q;
  logic [NUM_PORTS-1:0] covered;

  always_comb begin
    covered   = sent_q | SELF_BIT | (NUM_PORTS'(1) << dest);
    last_copy = !bcast || (covered == ALL_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest   <= '0;
      bcast  <= 1'b0;
      sent_q <= '0;
    end else if (load) begin
      dest   <= load_bcast ? FIRST : load_dst;
      bcast  <= load_bcast;
      sent_q <= '0;
    end else if (advance && bcast) begin
      if (last_copy) begin
        dest   <= FIRST;
        sent_q <= '0;
      end else begin
        dest   <= PW'(next_peer(int'(dest), PORT_IDX, NUM_PORTS));
        sent_q <= sent_q | (NUM_PORTS'(1) << dest);
      end
    end
  end
endmodule

// File: rtl/msg_port_fsm.sv
module msg_port_fsm
  import msg_port_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4,
  parameter int PORT_IDX  = 0,
  parameter int PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  input  logic              in_avail,
  output logic              in_pop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ctrl,
  output logic              out_wr,
  input  logic              out_full,
  output logic              req,
  output logic [PW-1:0]     dest,
  input  logic              grant
);
  port_state_e state_q, state_d;

  logic hdr_take;
  logic wr_fire;
  logic last_copy;
  logic word_done;
  logic word_is_tail;
  logic tail_sent;
  logic bcast_active;
  logic hdr_is_bcast;

  assign hdr_take     = (state_q == ST_HEADER) && in_avail && in_ctrl;
  assign hdr_is_bcast = (hdr_cmd(in_data[31:0]) == CMD_BCAST);

  assign in_pop = ((state_q == ST_HEADER) && in_avail) ||
                  ((state_q == ST_FETCH) && grant && in_avail);

  assign wr_fire   = (state_q == ST_SEND) && grant && !out_full;
  assign word_done = wr_fire && last_copy;
  assign tail_sent = word_done && word_is_tail;

  assign req    = (state_q == ST_EXTRACT) || (state_q == ST_SEND) || (state_q == ST_FETCH);
  assign out_wr = wr_fire;

  msg_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (in_pop),
    .load_is_hdr  (state_q == ST_HEADER),
    .load_data    (in_data),
    .load_ctrl    (in_ctrl),
    .word         (out_data),
    .word_ctrl    (out_ctrl),
    .word_is_tail (word_is_tail)
  );

  msg_bcast_seq #(.NUM_PORTS(NUM_PORTS), .PORT_IDX(PORT_IDX), .PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hdr_take),
    .load_dst   (in_data[HDR_DST_LSB +: PW]),
    .load_bcast (hdr_is_bcast),
    .advance    (wr_fire),
    .dest       (dest),
    .bcast      (bcast_active),
    .last_copy  (last_copy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CHECK:   if (in_avail) state_d = ST_HEADER;
      ST_HEADER:  if (in_avail) state_d = in_ctrl ? ST_EXTRACT : ST_CHECK;
      ST_EXTRACT: if (grant) state_d = ST_SEND;
      ST_SEND:    if (word_done) state_d = word_is_tail ? ST_CHECK : ST_FETCH;
      ST_FETCH:   if (grant && in_avail) state_d = ST_SEND;
      default:    state_d = ST_CHECK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_CHECK;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/msg_port_fsm_chk.sv
module msg_port_fsm_chk #(
  parameter int DATA_W   = 32,
  parameter int PORT_IDX = 0,
  parameter int PW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_avail,
  input logic              in_pop,
  input logic              out_wr,
  input logic              out_full,
  input logic [DATA_W-1:0] out_data,
  input logic              grant,
  input logic              req,
  input logic [PW-1:0]     dest,
  input logic              bcast_active,
  input logic              tail_sent
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !req && !out_wr); // R1

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> in_avail); // R4

  AST_WRITE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> grant && !out_full && req); // R5

  AST_STALL_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req && !grant |=> $stable(out_data)); // R6

  AST_REQ_DROPS_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    tail_sent |=> !req); // R7

  AST_BCAST_SKIPS_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr && bcast_active |-> dest != PW'(PORT_IDX)); // R8

  AST_DEST_STABLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    req && !grant |=> $stable(dest)); // R9
endmodule

bind msg_port_fsm msg_port_fsm_chk #(.DATA_W(DATA_W), .PORT_IDX(PORT_IDX), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_avail     (in_avail),
  .in_pop       (in_pop),
  .out_wr       (out_wr),
  .out_full     (out_full),
  .out_data     (out_data),
  .grant        (grant),
  .req          (req),
  .dest         (dest),
  .bcast_active (bcast_active),
  .tail_sent    (tail_sent)
);

// File: tb/msg_port_fsm_tb.sv
module msg_port_fsm_tb;
  localparam int NP   = 4;
  localparam int SELF = 2;
  localparam int DW   = 32;
  localparam int PW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ctrl = 1'b0;
  logic          in_avail = 1'b0;
  logic          in_pop;
  logic [DW-1:0] out_data;
  logic          out_ctrl;
  logic          out_wr;
  logic          out_full = 1'b0;
  logic          req;
  logic [PW-1:0] dest;
  logic          grant = 1'b0;

  always #5 clk = ~clk;

  msg_port_fsm #(.DATA_W(DW), .NUM_PORTS(NP), .PORT_IDX(SELF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_avail(in_avail), .in_pop(in_pop), .out_data(out_data),
    .out_ctrl(out_ctrl), .out_wr(out_wr), .out_full(out_full),
    .req(req), .dest(dest), .grant(grant)
  );

  typedef struct packed { logic ctrl; logic [DW-1:0] data; } src_t;
  typedef struct { logic [DW-1:0] data; logic ctrl; int port; bit ends; } exp_t;

  src_t src_q[$];
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit rand_grant = 0;
  bit rand_full  = 0;
  bit grant_off  = 0;
  bit pop_due    = 0;
  bit req_low_due = 0;
  bit prev_stall = 0;
  logic [PW-1:0] prev_dest = '0;
  logic [DW-1:0] prev_word = '0;
  bit finished = 0;

  task automatic fail(string req_tag, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
  endtask

  // Queue one message: inbound words plus the writes the requirements predict.
  task automatic send_msg(int dst, int cmd, int ndata, int base);
    logic [DW-1:0] words[$];
    logic          ctl[$];
    words.push_back({5'd0, 10'(ndata), 4'(base), 4'(cmd), 4'(base + 1), 4'(dst), 1'b1});
    ctl.push_back(1'b1);
    for (int i = 0; i < ndata; i++) begin
      words.push_back(32'hA500_0000 + 32'(base * 256 + i));
      ctl.push_back(1'b0);
    end
    words.push_back({12'd0, 11'(base * 3 + 7), 4'd0, 4'(SELF), 1'b1});
    ctl.push_back(1'b1);
    for (int w = 0; w < words.size(); w++) begin
      src_q.push_back({ctl[w], words[w]});
      if (cmd == 2) begin
        for (int k = 1; k < NP; k++)
          exp_q.push_back('{words[w], ctl[w], (SELF + k) % NP,
                            (w == words.size() - 1) && (k == NP - 1)});
      end else begin
        exp_q.push_back('{words[w], ctl[w], dst % NP, (w == words.size() - 1)});
      end
    end
  endtask

  task automatic drain();
    while (src_q.size() != 0 || exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk); #2;
    checks++;
    if (req !== 1'b0) fail("R7", "req after message end", req, 0);
  endtask

  // Inbound queue, stall drivers and per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_due && src_q.size() != 0) void'(src_q.pop_front());
      in_avail = (src_q.size() != 0);
      in_data  = in_avail ? src_q[0].data : '0;
      in_ctrl  = in_avail ? src_q[0].ctrl : 1'b0;
      grant    = grant_off ? 1'b0 : (rand_grant ? (($urandom % 3) != 0) : 1'b1);
      out_full = rand_full ? (($urandom % 4) == 0) : 1'b0;
      #1;
      if (req_low_due) begin
        checks++;
        if (req !== 1'b0) fail("R7", "req after tail write", req, 0);
        req_low_due = 0;
      end
      if (prev_stall) begin
        checks++;
        if (dest !== prev_dest) fail("R9", "dest moved during stall", dest, prev_dest);
        if (out_data !== prev_word) fail("R6", "held word moved during stall", out_data, prev_word);
      end
      if (in_pop && !in_avail) begin
        checks++;
        fail("R4", "pop with empty stream", in_pop, 0);
      end
      if (out_wr) begin
        checks++;
        if (!grant || out_full || !req)
          fail("R5", "write without grant/room/req", {grant, out_full, req}, 3'b101);
        if (exp_q.size() == 0) begin
          fail("R6", "unexpected write", out_data, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_data !== e.data) fail("R6", "word data", out_data, e.data);
          if (out_ctrl !== e.ctrl) fail("R5", "control bit", out_ctrl, e.ctrl);
          if (int'(dest) != e.port) fail("R3/R8", "dest port", dest, e.port);
          if (e.ends) req_low_due = 1;
        end
      end
      prev_stall = req && !grant;
      prev_dest  = dest;
      prev_word  = out_data;
      pop_due    = in_pop;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    checks++;
    if (req !== 1'b0 || out_wr !== 1'b0 || in_pop !== 1'b0)
      fail("R1", "outputs in reset", {req, out_wr, in_pop}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    checks++;
    if (req !== 1'b0 || out_wr !== 1'b0) fail("R1", "outputs after reset", {req, out_wr}, 0);

    // R3 point-to-point to port 3, free-running grant
    send_msg(3, 1, 3, 1);
    drain();

    // R2 stray data word dropped, then a normal message
    src_q.push_back({1'b0, 32'hDEAD_BEEF});
    send_msg(0, 1, 2, 2);
    drain();

    // R3 unknown command behaves as point-to-point, header immediately followed by tail
    send_msg(1, 5, 0, 3);
    drain();

    // R8 broadcast skipping own index with wrap
    send_msg(0, 2, 2, 4);
    drain();

    // R4 grant withheld: header taken, nothing written or popped beyond it
    grant_off = 1;
    send_msg(3, 1, 1, 5);
    repeat (20) @(posedge clk);
    @(negedge clk); #2;
    checks++;
    if (src_q.size() != 2) fail("R4", "words left without grant", src_q.size(), 2);
    checks++;
    if (req !== 1'b1) fail("R4", "req while waiting for grant", req, 1);
    grant_off = 0;
    drain();

    // R6 random stalls, mixed traffic, upper destination bits ignored (13 -> port 1)
    rand_grant = 1;
    rand_full  = 1;
    send_msg(13, 1, 4, 6);
    send_msg(0, 2, 3, 7);
    send_msg(2, 2, 0, 8);
    send_msg(7, 3, 2, 9);
    drain();
    for (int m = 0; m < 6; m++) send_msg(m, (m % 2) ? 2 : 1, m, 10 + m);
    drain();

    checks++;
    if (exp_q.size() != 0 || src_q.size() != 0)
      fail("R6", "leftover words", exp_q.size() + src_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule